// File: doc/BRIEF.md
# Guest Timer Compare Unit

This unit holds a 64-bit compare value for the timer of a guest (virtual supervisor) operating system and raises the guest timer pending bit once the guest's view of time reaches it. Guest time is machine time plus a 64-bit offset. The offset is held in a second register that the hypervisor programs. The sum wraps modulo 2^64, so the offset can move guest time forwards or backwards.

Both registers are reached through a CSR-style port. The port carries an address, write data, read and write strobes, the current privilege mode, the virtualization flag and a flag for 32-bit register width. Access from the guest is gated at two levels by the timer-enable bits of the machine and hypervisor counter-enable registers. A blocked access raises either the ordinary illegal-instruction flag or the virtual-instruction flag. The pending output is the OR of the registered compare result and a pending bit that the hypervisor injects from software.

Top module: `gtimer_cmp`

## Requirements
- R1: Both registers are 64 bits wide. With `narrow_xlen`=1, address 0x208 selects bits 31:0 of the compare register and 0x209 selects bits 63:32. A narrow write changes only the selected half. A narrow read returns that half zero-extended. With `narrow_xlen`=0, address 0x208 reads and writes all 64 bits, and any access to 0x209 sets `fault_illegal`.
- R2: The timer level is 1 when the unsigned 64-bit value (`mtime` + offset) is greater than or equal to the compare value. It is registered, so `guest_tip` shows the result computed from the values present at the previous rising edge.
- R3: While the compare value stays at or below (`mtime` + offset), the level remains 1. Writing a compare value above that sum clears it.
- R4: The sum `mtime` + offset wraps modulo 2^64, and the comparison uses the wrapped value.
- R5: `guest_tip` is the logical OR of `inj_tip` and the timer level. It follows `inj_tip` in the same cycle.
- R6: `guest_tip` does not depend on `virt_on`.
- R7: Privilege codes are 2'b11 machine, 2'b01 supervisor and 2'b00 user. A compare access in supervisor mode with `virt_on`=1 and `m_tm_en`=0 sets `fault_illegal` and leaves `fault_virtual` at 0, whatever `h_tm_en` is.
- R8: A compare access in supervisor mode with `virt_on`=1, `m_tm_en`=1 and `h_tm_en`=0 sets `fault_virtual` and leaves `fault_illegal` at 0.
- R9: A compare access in supervisor mode with `virt_on`=1 is permitted when both enable bits are 1. Compare accesses from machine mode, or from supervisor mode with `virt_on`=0, are always permitted. Accesses from user mode set `fault_illegal`.
- R10: The offset register sits at 0x605 (full or low half) and at 0x615 (high half, narrow mode only). It is accessible from machine mode and from supervisor mode with `virt_on`=0. Any other mode sets `fault_illegal`.
- R11: A faulting access changes no register and returns `csr_rdata` = 0.
- R12: After reset the compare register is all ones, the offset is zero and the timer level is 0.
- R13: An access to any other address raises no fault flag and returns `csr_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 64 | Write data |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| priv_mode | input | 2 | Privilege mode of the access |
| virt_on | input | 1 | Virtualization flag |
| narrow_xlen | input | 1 | 1 selects 32-bit register width |
| mtime | input | 64 | Machine time |
| inj_tip | input | 1 | Pending bit injected by hypervisor software |
| m_tm_en | input | 1 | Timer enable bit of the machine counter-enable register |
| h_tm_en | input | 1 | Timer enable bit of the hypervisor counter-enable register |
| csr_rdata | output | 64 | Read data, combinational |
| fault_illegal | output | 1 | Illegal-instruction flag |
| fault_virtual | output | 1 | Virtual-instruction flag |
| guest_tip | output | 1 | Guest timer pending bit |

## Verification
The assertions assume three things. First, `csr_rd` and `csr_wr` are never both asserted. Second, the address, mode and enable inputs hold steady for the whole cycle a strobe is high. Third, `priv_mode` never takes the reserved code 2'b10. The bench drives every access from a single task that sets all of these fields together at the falling edge and drops the strobes just after the next rising edge, so each access lasts exactly one cycle. Only the three defined privilege codes are used. Machine time changes only between accesses, which makes the one-cycle latency of the level observable on its own.

// File: rtl/gtc_pkg.sv
`timescale 1ns/1ps
package gtc_pkg;

    typedef enum logic [1:0] {
        PRV_U = 2'b00,
        PRV_S = 2'b01,
        PRV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CMP  = 2'd1,
        SEL_DLT  = 2'd2
    } sel_e;

    // decoded access
    typedef struct packed {
        logic hit;
        sel_e sel;
        logic hi;
        logic illegal;
        logic virt_illegal;
    } acc_t;

    function automatic logic acc_ok(acc_t a);
        return a.hit && !a.illegal && !a.virt_illegal;
    endfunction

endpackage

// File: rtl/gtc_access_gate.sv
`timescale 1ns/1ps
module gtc_access_gate
    import gtc_pkg::*;
#(
    parameter int AW = 12,
    parameter logic [AW-1:0] CMP_LO = 12'h208,
    parameter logic [AW-1:0] CMP_HI = 12'h209,
    parameter logic [AW-1:0] DLT_LO = 12'h605,
    parameter logic [AW-1:0] DLT_HI = 12'h615
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          req,
    input  logic [1:0]    priv,
    input  logic          virt,
    input  logic          narrow,
    input  logic          m_tm,
    input  logic          h_tm,
    output acc_t          acc
);

    logic hit_cmp, hit_dlt;

    always_comb begin
        hit_cmp = (addr == CMP_LO) || (addr == CMP_HI);
        hit_dlt = (addr == DLT_LO) || (addr == DLT_HI);
        acc     = '0;
        acc.sel = SEL_NONE;
        if (req && (hit_cmp || hit_dlt)) begin
            acc.hit = 1'b1;
            acc.sel = hit_cmp ? SEL_CMP : SEL_DLT;
            acc.hi  = (addr == CMP_HI) || (addr == DLT_HI);
            if (acc.hi && !narrow) begin
                acc.illegal = 1'b1;          // high half only exists in narrow mode
            end else if (priv == PRV_M) begin
                acc.illegal = 1'b0;
            end else if (priv != PRV_S) begin
                acc.illegal = 1'b1;
            end else if (virt) begin
                if (hit_dlt || !m_tm)
                    acc.illegal = 1'b1;      // machine level gate first
                else if (!h_tm)
                    acc.virt_illegal = 1'b1; // hypervisor level gate
            end
        end
    end

    // R7: machine gate closed always yields the ordinary fault
    p_mgate_r7: assert property (@(posedge clk) disable iff (rst)
        (req && (addr == CMP_LO) && priv == PRV_S && virt && !m_tm)
        |-> (acc.illegal && !acc.virt_illegal));

    // R8: at most one kind of fault per access
    p_one_fault_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({acc.illegal, acc.virt_illegal}));

    // R9: both gates open lets the guest through
    p_open_r9: assert property (@(posedge clk) disable iff (rst)
        (req && (addr == CMP_LO) && priv == PRV_S && virt && m_tm && h_tm)
        |-> (acc.hit && !acc.illegal && !acc.virt_illegal));

endmodule

// File: rtl/gtc_regs.sv
`timescale 1ns/1ps
module gtc_regs
    import gtc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  acc_t         acc,
    input  logic         wr,
    input  logic         narrow,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cmp_q,
    output logic [W-1:0] dlt_q,
    output logic [W-1:0] rdata
);

    localparam int HALF = W / 2;
    localparam int NREG = 2;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam sel_e         MY   = (g == 0) ? SEL_CMP : SEL_DLT;
        localparam logic [W-1:0] INIT = (g == 0) ? {W{1'b1}} : {W{1'b0}};
        logic [W-1:0] q;
        logic         take;
        assign take = wr && acc_ok(acc) && (acc.sel == MY);
        always_ff @(posedge clk) begin
            if (rst)
                q <= INIT;
            else if (take) begin
                if (!narrow)
                    q <= wdata;
                else if (acc.hi)
                    q <= {wdata[HALF-1:0], q[HALF-1:0]};
                else
                    q <= {q[W-1:HALF], wdata[HALF-1:0]};
            end
        end
    end

    assign cmp_q = g_reg[0].q;
    assign dlt_q = g_reg[1].q;

    logic [W-1:0] src;
    always_comb begin
        src   = (acc.sel == SEL_CMP) ? cmp_q : dlt_q;
        rdata = '0;
        if (acc_ok(acc)) begin
            if (!narrow)
                rdata = src;
            else if (acc.hi)
                rdata = {{HALF{1'b0}}, src[W-1:HALF]};
            else
                rdata = {{HALF{1'b0}}, src[HALF-1:0]};
        end
    end

    // R11: a faulting write leaves both registers untouched
    p_fault_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (wr && acc.hit && (acc.illegal || acc.virt_illegal))
        |=> ($stable(cmp_q) && $stable(dlt_q)));

    // R1: a high-half write keeps the low halves
    p_hi_keeps_lo_r1: assert property (@(posedge clk) disable iff (rst)
        (wr && acc.hit && acc.hi && !acc.illegal && !acc.virt_illegal)
        |=> ($stable(cmp_q[HALF-1:0]) && $stable(dlt_q[HALF-1:0])));

endmodule

// File: rtl/gtc_compare.sv
`timescale 1ns/1ps
module gtc_compare #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] now,
    input  logic [W-1:0] dlt,
    input  logic [W-1:0] cmp,
    output logic         lvl
);

    logic [W-1:0] guest_now;

    assign guest_now = now + dlt;   // wraps modulo 2^W

    always_ff @(posedge clk) begin
        if (rst)
            lvl <= 1'b0;
        else
            lvl <= (guest_now >= cmp);
    end

    // R2: a zero compare value is always reached one cycle later
    p_zero_cmp_r2: assert property (@(posedge clk) disable iff (rst)
        (cmp == '0) |=> lvl);

endmodule

// File: rtl/gtimer_cmp.sv
`timescale 1ns/1ps
module gtimer_cmp
    import gtc_pkg::*;
#(
    parameter int AW = 12,
    parameter int W  = 64,
    parameter logic [AW-1:0] CMP_LO = 12'h208,
    parameter logic [AW-1:0] CMP_HI = 12'h209,
    parameter logic [AW-1:0] DLT_LO = 12'h605,
    parameter logic [AW-1:0] DLT_HI = 12'h615
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] csr_addr,
    input  logic [W-1:0]  csr_wdata,
    input  logic          csr_rd,
    input  logic          csr_wr,
    input  logic [1:0]    priv_mode,
    input  logic          virt_on,
    input  logic          narrow_xlen,
    input  logic [W-1:0]  mtime,
    input  logic          inj_tip,
    input  logic          m_tm_en,
    input  logic          h_tm_en,
    output logic [W-1:0]  csr_rdata,
    output logic          fault_illegal,
    output logic          fault_virtual,
    output logic          guest_tip
);

    acc_t         acc;
    logic [W-1:0] cmp_q, dlt_q;
    logic         lvl;

    gtc_access_gate #(
        .AW(AW), .CMP_LO(CMP_LO), .CMP_HI(CMP_HI),
        .DLT_LO(DLT_LO), .DLT_HI(DLT_HI)
    ) gate_i (
        .clk(clk), .rst(rst), .addr(csr_addr), .req(csr_rd || csr_wr),
        .priv(priv_mode), .virt(virt_on), .narrow(narrow_xlen),
        .m_tm(m_tm_en), .h_tm(h_tm_en), .acc(acc)
    );

    gtc_regs #(.W(W)) regs_i (
        .clk(clk), .rst(rst), .acc(acc), .wr(csr_wr), .narrow(narrow_xlen),
        .wdata(csr_wdata), .cmp_q(cmp_q), .dlt_q(dlt_q), .rdata(csr_rdata)
    );

    gtc_compare #(.W(W)) cmp_i (
        .clk(clk), .rst(rst), .now(mtime), .dlt(dlt_q), .cmp(cmp_q), .lvl(lvl)
    );

    assign fault_illegal = acc.illegal;
    assign fault_virtual = acc.virt_illegal;
    assign guest_tip     = inj_tip || lvl;

endmodule

// File: tb/gtimer_cmp_tb_top.sv
`timescale 1ns/1ps
module gtimer_cmp_tb_top;

    localparam logic [11:0] A_CLO = 12'h208;
    localparam logic [11:0] A_CHI = 12'h209;
    localparam logic [11:0] A_DLO = 12'h605;
    localparam logic [1:0]  M = 2'b11, S = 2'b01, U = 2'b00;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic        csr_rd = 1'b0, csr_wr = 1'b0;
    logic [1:0]  priv_mode = M;
    logic        virt_on = 1'b0, narrow_xlen = 1'b0;
    logic [63:0] mtime = '0;
    logic        inj_tip = 1'b0, m_tm_en = 1'b1, h_tm_en = 1'b1;
    logic [63:0] csr_rdata;
    logic        fault_illegal, fault_virtual, guest_tip;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [63:0] r_d;
    logic        r_ill, r_vil;

    always #4 clk = ~clk;   // 125 MHz

    gtimer_cmp dut_i (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rd(csr_rd), .csr_wr(csr_wr), .priv_mode(priv_mode),
        .virt_on(virt_on), .narrow_xlen(narrow_xlen), .mtime(mtime),
        .inj_tip(inj_tip), .m_tm_en(m_tm_en), .h_tm_en(h_tm_en),
        .csr_rdata(csr_rdata), .fault_illegal(fault_illegal),
        .fault_virtual(fault_virtual), .guest_tip(guest_tip)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one-cycle access; captures combinational results before the edge
    task automatic acc(input logic [11:0] a, input logic [63:0] d, input logic w,
                       input logic [1:0] p, input logic v);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_wr = w; csr_rd = !w;
        priv_mode = p; virt_on = v;
        #1;
        r_d = csr_rdata; r_ill = fault_illegal; r_vil = fault_virtual;
        @(posedge clk);
        #1;
        csr_rd = 1'b0; csr_wr = 1'b0; virt_on = 1'b0; priv_mode = M;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        mtime = 64'd100;
        acc(A_CLO, 0, 0, M, 0);
        chk("R12 cmp reset", r_d, ONES);
        acc(A_DLO, 0, 0, M, 0);
        chk("R12 delta reset", r_d, 64'd0);
        chk("R12 tip reset", {63'd0, guest_tip}, 64'd0);
    endtask

    task automatic t_compare();
        mtime = 64'd1000;
        acc(A_CLO, 64'd1000, 1, S, 0);
        tick();
        chk("R2 equal sets", {63'd0, guest_tip}, 64'd1);
        acc(A_CLO, 64'd1001, 1, S, 0);
        tick();
        chk("R3 raise clears", {63'd0, guest_tip}, 64'd0);
        @(negedge clk);
        mtime = 64'd1001;
        #1;
        chk("R2 latency", {63'd0, guest_tip}, 64'd0);
        tick();
        chk("R2 time reaches", {63'd0, guest_tip}, 64'd1);
        tick(); tick();
        chk("R3 stays", {63'd0, guest_tip}, 64'd1);
        acc(A_CLO, ONES, 1, M, 0);
        tick();
        chk("R3 cleared", {63'd0, guest_tip}, 64'd0);
    endtask

    task automatic t_wrap();
        mtime = 64'd20;
        acc(A_DLO, ONES - 64'd9, 1, M, 0);    // offset of -10
        acc(A_CLO, 64'd11, 1, M, 0);
        tick();
        chk("R4 wrapped below", {63'd0, guest_tip}, 64'd0);
        acc(A_CLO, 64'd10, 1, M, 0);
        tick();
        chk("R4 wrapped equal", {63'd0, guest_tip}, 64'd1);
        acc(A_CLO, ONES - 64'd4, 1, M, 0);
        tick();
        chk("R4 no carry kept", {63'd0, guest_tip}, 64'd0);
        acc(A_DLO, 64'd0, 1, M, 0);
    endtask

    task automatic t_narrow();
        narrow_xlen = 1'b1;
        acc(A_CLO, 64'hDEAD_0000_1111_2222, 1, M, 0);
        acc(A_CHI, 64'h5555_0000_AAAA_BBBB, 1, M, 0);
        acc(A_CHI, 0, 0, M, 0);
        chk("R1 narrow high read", r_d, 64'h0000_0000_AAAA_BBBB);
        acc(A_CLO, 0, 0, M, 0);
        chk("R1 narrow low read", r_d, 64'h0000_0000_1111_2222);
        narrow_xlen = 1'b0;
        acc(A_CLO, 0, 0, M, 0);
        chk("R1 full read", r_d, 64'hAAAA_BBBB_1111_2222);
        acc(A_CHI, 0, 0, M, 0);
        chk("R1 high addr wide mode", {63'd0, r_ill}, 64'd1);
    endtask

    task automatic t_gate();
        m_tm_en = 1'b0; h_tm_en = 1'b1;
        acc(A_CLO, 64'h77, 1, S, 1);
        chk("R7 illegal", {62'd0, r_ill, r_vil}, 64'd2);
        chk("R11 fault rdata", r_d, 64'd0);
        acc(A_CLO, 0, 0, M, 0);
        chk("R11 no write", r_d, 64'hAAAA_BBBB_1111_2222);
        m_tm_en = 1'b1; h_tm_en = 1'b0;
        acc(A_CLO, 64'h77, 1, S, 1);
        chk("R8 virtual fault", {62'd0, r_ill, r_vil}, 64'd1);
        acc(A_CLO, 0, 0, M, 0);
        chk("R11 no write virt", r_d, 64'hAAAA_BBBB_1111_2222);
        h_tm_en = 1'b1;
        acc(A_CLO, 64'h77, 1, S, 1);
        chk("R9 permitted", {62'd0, r_ill, r_vil}, 64'd0);
        acc(A_CLO, 0, 0, S, 1);
        chk("R9 guest readback", r_d, 64'h77);
        acc(A_CLO, 0, 0, U, 0);
        chk("R9 user illegal", {62'd0, r_ill, r_vil}, 64'd2);
        m_tm_en = 1'b0;
        acc(A_CLO, 0, 0, S, 0);
        chk("R9 host ungated", {62'd0, r_ill, r_vil}, 64'd0);
        m_tm_en = 1'b1;
    endtask

    task automatic t_delta_access();
        acc(A_DLO, 64'd5, 1, S, 1);
        chk("R10 guest delta illegal", {62'd0, r_ill, r_vil}, 64'd2);
        acc(A_DLO, 0, 0, M, 0);
        chk("R10 guest no write", r_d, 64'd0);
        acc(A_DLO, 64'd5, 1, S, 0);
        chk("R10 host delta ok", {62'd0, r_ill, r_vil}, 64'd0);
        acc(A_DLO, 0, 0, M, 0);
        chk("R10 host readback", r_d, 64'd5);
        acc(A_DLO, 64'd0, 1, M, 0);
    endtask

    task automatic t_inject();
        mtime = 64'd50;
        acc(A_CLO, ONES, 1, M, 0);
        tick();
        @(negedge clk);
        inj_tip = 1'b1;
        #1;
        chk("R5 inject", {63'd0, guest_tip}, 64'd1);
        inj_tip = 1'b0;
        #1;
        chk("R5 inject off", {63'd0, guest_tip}, 64'd0);
        acc(A_CLO, 64'd0, 1, M, 0);
        tick();
        @(negedge clk);
        virt_on = 1'b1;
        #1;
        chk("R6 V=1", {63'd0, guest_tip}, 64'd1);
        virt_on = 1'b0;
        #1;
        chk("R6 V=0", {63'd0, guest_tip}, 64'd1);
        inj_tip = 1'b1;
        #1;
        chk("R5 both", {63'd0, guest_tip}, 64'd1);
        inj_tip = 1'b0;
    endtask

    task automatic t_unmapped();
        acc(12'h100, 64'd9, 1, U, 0);
        chk("R13 no fault", {62'd0, r_ill, r_vil}, 64'd0);
        acc(12'h100, 0, 0, U, 1);
        chk("R13 rdata zero", r_d, 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_compare();
        t_wrap();
        t_narrow();
        t_gate();
        t_delta_access();
        t_inject();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule